// File: doc/BRIEF.md
# Pipelined Fixed-Point Leaky Integrate-and-Fire Neuron

This block models one leaky integrate-and-fire neuron in signed 16-bit fixed point with 8 fraction bits. On every clock edge the membrane value moves toward a resting level. The input current pushes it away from that level. When the membrane value rises above a firing level, the block emits a spike and returns the membrane to rest. The leak is computed by multiplying by a reciprocal of the time constant, which avoids a divider. The sum of leak and current is then scaled by a fixed time step.

The time-step multiply produces a double-width product. A parameter chooses how that product reaches the truncating arithmetic shift. It can pass straight through logic, or it can go through one or more full-width registers. Registering the product breaks the longest path in the loop, at the cost of applying each derivative one cycle late. A constant output reports how many product registers are present, so the surrounding logic can account for the delay.

The pins are plain and there is no handshake. The neuron advances on every clock, and the input current is sampled on every rising edge.

Top module: `lif_neuron`

## Requirements
- R1: While `rst_n` is low, `v_out` holds -16640 (-65.0, pattern 0xBF00) and `spike_out` is 0.
- R2: `latency` equals the number of product registers: 1 in the default build, 0 when `PIPE_STAGES` is 0.
- R3: With one stage, the 32-bit product of derivative and time step (Q8.8 constant 26) is captured on the rising edge. The truncation uses the captured value, so a current step first changes `v_out` two edges after it is applied.
- R4: The derivative is d = sat16((((-16640 - v) * 26) >>> 8) + I), where I is `cur_in`, 26 is the Q8.8 reciprocal of the time constant 10, and the capacitance is 1. With I = 0 and v at rest, v does not change.
- R5: The candidate membrane value is sat16(v + sat16(P >>> 8)), where P = d * 26 is taken from the register or directly from the multiply, and >>> rounds toward minus infinity.
- R6: If the candidate is strictly greater than -12800 (-50.0), v becomes -16640 and `spike_out` is 1 for that cycle. Otherwise v takes the candidate and `spike_out` is 0. `v_out` never exceeds -12800.
- R7: The addition into v saturates at -32768 instead of wrapping. A sustained I = -32768 drives `v_out` to -32768, where it stays.
- R8: With `PIPE_STAGES` = 0, the product feeds the shift directly. From rest, I = 2560 (10.0) moves `v_out` to -16380 at the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_in | input | 16 | Signed Q8.8 input current |
| spike_out | output | 1 | Registered spike pulse |
| v_out | output | 16 | Signed Q8.8 membrane value |
| latency | output | LAT_W | Constant count of product registers |

## Verification
On every cycle, the assertions check four things. The membrane never sits above the firing level. A spike always coincides with the reset value. Each new membrane value is the clamped sum of the previous value and the previous truncated step, which also covers the no-wrap floor. When one stage is built, the product used by the truncation is the product formed one edge earlier. The reset value, the latency constant and the exact derivative arithmetic can only be shown by the bench's scenarios, because they compare the outputs against an independent model. The same holds for the contrast between the one-stage and combinational builds, the recurrence of spikes under steady current and the settling at the negative floor.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int DATA_W = 16;
  localparam int FRAC_W = 8;
  // -65.0, -50.0 in Q8.8
  localparam logic signed [DATA_W-1:0] REST_Q  = -16'sd16640;
  localparam logic signed [DATA_W-1:0] FIRE_Q  = -16'sd12800;
  // 0.1 in Q8.8, used both as 1/tau and as the time step
  localparam logic signed [DATA_W-1:0] TENTH_Q = 16'sd26;
endpackage

// File: rtl/lif_sat.sv
module lif_sat #(
  parameter int IN_W  = 33,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] y
);
  localparam logic signed [IN_W-1:0] HI = IN_W'((longint'(1) <<< (OUT_W-1)) - 1);
  localparam logic signed [IN_W-1:0] LO = -HI - 1;

  always_comb begin
    if (x > HI)      y = OUT_W'(HI);
    else if (x < LO) y = OUT_W'(LO);
    else             y = OUT_W'(x);
  end
endmodule

// File: rtl/lif_deriv.sv
module lif_deriv #(
  parameter int DW = 16,
  parameter int FRAC = 8,
  parameter logic signed [DW-1:0] REST_V = -16'sd16640,
  parameter logic signed [DW-1:0] TAU_RECIP = 16'sd26
) (
  input  logic signed [DW-1:0] v_in,
  input  logic signed [DW-1:0] cur_in,
  output logic signed [DW-1:0] deriv
);
  localparam int PW = 2*DW + 2;

  logic signed [DW:0]   gap;
  logic signed [PW-1:0] leak_full;
  logic signed [PW-1:0] total;

  assign gap       = (DW+1)'(REST_V) - (DW+1)'(v_in);
  assign leak_full = PW'(gap) * PW'(TAU_RECIP);
  assign total     = (leak_full >>> FRAC) + PW'(cur_in);

  lif_sat #(.IN_W(PW), .OUT_W(DW)) u_sat (.x(total), .y(deriv));
endmodule

// File: rtl/lif_dt_stage.sv
module lif_dt_stage #(
  parameter int DW = 16,
  parameter int FRAC = 8,
  parameter int STAGES = 1,
  parameter logic signed [DW-1:0] DT_STEP = 16'sd26
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [DW-1:0]   deriv,
  output logic signed [2*DW-1:0] prod_now,
  output logic signed [2*DW-1:0] prod_used,
  output logic signed [DW-1:0]   trunc
);
  localparam int PW = 2*DW;

  logic signed [PW-1:0] shifted;

  assign prod_now = PW'(deriv) * PW'(DT_STEP);

  generate
    if (STAGES == 0) begin : g_comb
      assign prod_used = prod_now;
    end else begin : g_reg
      logic signed [PW-1:0] pipe_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
        end else begin
          pipe_q[0] <= prod_now;
          for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
      end
      assign prod_used = pipe_q[STAGES-1];
    end
  endgenerate

  assign shifted = prod_used >>> FRAC;

  lif_sat #(.IN_W(PW), .OUT_W(DW)) u_sat (.x(shifted), .y(trunc));
endmodule

// File: rtl/lif_state.sv
module lif_state #(
  parameter int DW = 16,
  parameter logic signed [DW-1:0] THRESH_V = -16'sd12800,
  parameter logic signed [DW-1:0] RESET_V  = -16'sd16640
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] trunc,
  output logic signed [DW-1:0] v_q,
  output logic                 spike_q
);
  logic signed [DW:0]   sum;
  logic signed [DW-1:0] v_next;
  logic                 fire;

  assign sum  = (DW+1)'(v_q) + (DW+1)'(trunc);
  lif_sat #(.IN_W(DW+1), .OUT_W(DW)) u_sat (.x(sum), .y(v_next));
  assign fire = v_next > THRESH_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= RESET_V;
      spike_q <= 1'b0;
    end else if (fire) begin
      v_q     <= RESET_V;
      spike_q <= 1'b1;
    end else begin
      v_q     <= v_next;
      spike_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron #(
  parameter int DW = lif_pkg::DATA_W,
  parameter int FRAC = lif_pkg::FRAC_W,
  parameter int PIPE_STAGES = 1,
  parameter int LAT_W = (PIPE_STAGES > 1) ? $clog2(PIPE_STAGES + 1) : 1,
  parameter logic signed [DW-1:0] REST_V    = lif_pkg::REST_Q,
  parameter logic signed [DW-1:0] THRESH_V  = lif_pkg::FIRE_Q,
  parameter logic signed [DW-1:0] TAU_RECIP = lif_pkg::TENTH_Q,
  parameter logic signed [DW-1:0] DT_STEP   = lif_pkg::TENTH_Q
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] cur_in,
  output logic                 spike_out,
  output logic signed [DW-1:0] v_out,
  output logic [LAT_W-1:0]     latency
);
  logic signed [DW-1:0]   deriv;
  logic signed [2*DW-1:0] dt_prod_now;
  logic signed [2*DW-1:0] dt_prod_used;
  logic signed [DW-1:0]   dt_trunc;

  assign latency = LAT_W'(PIPE_STAGES);

  lif_deriv #(
    .DW(DW), .FRAC(FRAC), .REST_V(REST_V), .TAU_RECIP(TAU_RECIP)
  ) u_deriv (
    .v_in(v_out), .cur_in(cur_in), .deriv(deriv)
  );

  lif_dt_stage #(
    .DW(DW), .FRAC(FRAC), .STAGES(PIPE_STAGES), .DT_STEP(DT_STEP)
  ) u_dt (
    .clk(clk), .rst_n(rst_n), .deriv(deriv),
    .prod_now(dt_prod_now), .prod_used(dt_prod_used), .trunc(dt_trunc)
  );

  lif_state #(
    .DW(DW), .THRESH_V(THRESH_V), .RESET_V(REST_V)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .trunc(dt_trunc),
    .v_q(v_out), .spike_q(spike_out)
  );
endmodule

// File: rtl/lif_neuron_chk.sv
module lif_neuron_chk #(
  parameter int DW = 16,
  parameter int PIPE_STAGES = 1,
  parameter logic signed [DW-1:0] THRESH_V = -16'sd12800,
  parameter logic signed [DW-1:0] RESET_V  = -16'sd16640
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   spike_out,
  input logic signed [DW-1:0]   v_out,
  input logic signed [DW-1:0]   trunc,
  input logic signed [2*DW-1:0] prod_now,
  input logic signed [2*DW-1:0] prod_used
);
  function automatic int clamp_dw(input int x);
    int hi;
    hi = (1 << (DW-1)) - 1;
    if (x > hi) return hi;
    if (x < -hi - 1) return -hi - 1;
    return x;
  endfunction

  AST_V_NOT_ABOVE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    v_out <= THRESH_V); // R6

  AST_SPIKE_WITH_REST: assert property (@(posedge clk) disable iff (!rst_n)
    spike_out |-> v_out == RESET_V); // R6

  AST_ACCUMULATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !spike_out) |->
      int'(v_out) == clamp_dw(int'($past(v_out)) + int'($past(trunc)))); // R5

  AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !spike_out && $past(v_out) < 0 && $past(trunc) < 0) |->
      v_out < 0); // R7

  generate
    if (PIPE_STAGES == 1) begin : g_one
      AST_PRODUCT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> prod_used == $past(prod_now)); // R3
    end
  endgenerate
endmodule

bind lif_neuron lif_neuron_chk #(
  .DW(DW), .PIPE_STAGES(PIPE_STAGES), .THRESH_V(THRESH_V), .RESET_V(REST_V)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spike_out(spike_out), .v_out(v_out),
  .trunc(dt_trunc), .prod_now(dt_prod_now), .prod_used(dt_prod_used)
);

// File: tb/lif_neuron_tb.sv
module lif_neuron_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic signed [15:0] REST = -16'sd16640;
  localparam logic signed [15:0] FIRE = -16'sd12800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] cur_in = '0;
  logic spike, spike_c;
  logic signed [15:0] v, v_c;
  logic [0:0] lat, lat_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  lif_neuron u_dut (.clk(clk), .rst_n(rst_n), .cur_in(cur_in),
                    .spike_out(spike), .v_out(v), .latency(lat));
  lif_neuron #(.PIPE_STAGES(0)) u_dut_comb (.clk(clk), .rst_n(rst_n), .cur_in(cur_in),
                    .spike_out(spike_c), .v_out(v_c), .latency(lat_c));

  typedef struct {
    logic signed [15:0] v;
    logic sp;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  int spikes_seen = 0;
  logic signed [15:0] m_v = REST;
  logic signed [31:0] m_preg = '0;

  function automatic longint sat16(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: apply one current sample, push the expected outputs of the next edge
  task automatic step(input logic signed [15:0] i, input string tag);
    longint gap, leak, d, prod, tr, sum;
    exp_t e;
    @(negedge clk);
    cur_in = i;
    gap  = longint'(REST) - longint'(m_v);
    leak = (gap * 26) >>> 8;
    d    = sat16(leak + longint'(i));
    prod = d * 26;
    tr   = sat16(longint'(m_preg) >>> 8);
    m_preg = 32'(prod);
    sum  = sat16(longint'(m_v) + tr);
    if (sum > longint'(FIRE)) begin
      m_v  = REST;
      e.sp = 1'b1;
    end else begin
      m_v  = 16'(sum);
      e.sp = 1'b0;
    end
    e.v = m_v;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(v === e.v, {e.tag, " v_out"}, longint'(v), longint'(e.v));
        check(spike === e.sp, {e.tag, " spike_out"}, longint'(spike), longint'(e.sp));
        if (spike === 1'b1) spikes_seen++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(v === REST, "R1 v_out in reset", longint'(v), longint'(REST));
    check(spike === 1'b0, "R1 spike_out in reset", longint'(spike), 0);
    check(lat === 1'b1, "R2 latency one stage", longint'(lat), 1);
    check(lat_c === 1'b0, "R2 latency combinational", longint'(lat_c), 0);
    @(negedge clk);
    rst_n = 1'b1;  // next edge with zero current at rest leaves the model state unchanged

    for (int k = 0; k < 5; k++) step(16'sd0, "R4");

    // R3: a current step is invisible at the first edge in the registered build
    step(16'sd2560, "R3");
    @(posedge clk);
    #1;
    check(v_c === -16'sd16380, "R8 combinational first edge", longint'(v_c), -16380);
    step(16'sd0, "R3");
    for (int k = 0; k < 4; k++) step(16'sd0, "R5");

    for (int k = 0; k < 40; k++) step(16'sd5120, "R6");
    for (int k = 0; k < 60; k++) step(-16'sd32768, "R7");
    wait (sb.size() == 0);
    @(posedge clk);
    #2;
    check(v === -16'sd32768, "R7 floor held", longint'(v), -32768);
    check(spikes_seen > 0, "R6 spikes under drive", spikes_seen, 1);

    step(16'sd700, "R5");
    step(-16'sd3000, "R5");
    step(16'sd32767, "R5");
    step(16'sd128, "R5");
    for (int k = 0; k < 30; k++) step(16'sd12000, "R6");
    wait (sb.size() == 0);
    @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule